// File: doc/BRIEF.md
# Codec Register Access Bridge

This block connects a 32-bit processor bus to the command and status slots of an audio/modem codec link. The processor sees each 16-bit codec register as one 32-bit word in a window. The bridge turns each read or write in that window into a single codec register transaction. It hands that transaction to the link frame engine. When the matching status slot comes back, the bridge returns the read data to the bus, padded with zeros in the upper half.

The modem GPIO register gets special treatment. A write to it goes over the link like any other write. A read of it never reaches the link. Instead, the bridge answers from a local copy that every received frame refreshes.

Only one link transaction can be in flight at a time. A read that gets no answer within a programmable number of received frames ends with a timeout flag.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, `busDone`, `busTimeout` and `cmdValid` are 0. A GPIO read issued before any frame has been received returns 0.
- R2: The codec register address on `cmdAddr` equals the bus byte offset shifted right by one bit (`busAddr[7:1]`). For example, bus offset 0xA8 gives codec address 0x54.
- R3: A write, including a write to GPIO address 0x54, raises `cmdValid` in the cycle after the request is accepted, with `cmdWrite`=1 and `cmdData` equal to `busWdata`. `busDone` pulses in the cycle after `cmdTaken` is seen, with `busTimeout`=0.
- R4: A read of any register other than 0x54 raises `cmdValid` with `cmdWrite`=0. It completes in the cycle after `stsValid` is seen with `stsAddr` equal to the requested address. `busRdata` is then `{16'h0, stsData}`.
- R5: A status slot whose address does not match the pending read does not complete it.
- R6: A read of codec address 0x54 never raises `cmdValid`. `busDone` rises in the cycle after the request is accepted, and `busRdata` is `{16'h0, shadow}`.
- R7: Each `frameStrobe` loads `gpioSlotData` into the shadow. A later GPIO read returns the most recently loaded value.
- R8: A pending read with no match completes on the N-th `frameStrobe` after `cmdTaken`, where N is `cfgTimeoutFrames` (a value of 0 acts as 1). It completes with `busTimeout`=1 and `busRdata`=0.
- R9: `cmdValid` and its fields stay stable until `cmdTaken`. No further command is raised before `busDone`.
- R10: `busDone` is a single-cycle pulse. A request that is still held in the pulse cycle is not taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Request valid, held until busDone |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset bits [7:1] within the codec window |
| busWdata | input | 16 | Write data (low half of the bus word) |
| busDone | output | 1 | One-cycle completion pulse |
| busRdata | output | 32 | Read data, zero-extended |
| busTimeout | output | 1 | Read timed out, valid with busDone |
| cmdValid | output | 1 | Command slot request to the frame engine |
| cmdWrite | output | 1 | Command is a write |
| cmdAddr | output | 7 | Codec register address |
| cmdData | output | 16 | Codec write data |
| cmdTaken | input | 1 | Frame engine has sent the command slot |
| frameStrobe | input | 1 | One pulse per received frame |
| gpioSlotData | input | 16 | GPIO bits of the received frame, valid with frameStrobe |
| stsValid | input | 1 | Status slot carries a register answer |
| stsAddr | input | 7 | Register address in the status slot |
| stsData | input | 16 | Register data in the status slot |
| cfgTimeoutFrames | input | 4 | Frames to wait before a read times out |

## Verification
The bench builds the block with its default parameters: a 7-bit codec address, a 4-bit frame counter and the GPIO register at 0x54. A 4-bit counter keeps every timeout window short, so the bench can reach the timeout limit many times. This includes the zero setting, which acts as one frame. Random word-aligned offsets cover the whole 64-register window, and GPIO accesses are mixed in. In those runs, random status answers arrive either before the limit or never.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } bridgeState_t;

  typedef struct packed {
    logic capture;     // latch request, clear read data
    logic loadShadow;  // read data from GPIO shadow
    logic loadSts;     // read data from status slot
  } dpStrobe_t;

endpackage

// File: rtl/codec_bridge_dp.sv
module codec_bridge_dp
  import codec_bridge_pkg::*;
#(
  parameter int BUS_AW  = 8,
  parameter int DATA_W  = 16,
  parameter int BUS_W   = 32,
  parameter int CODEC_AW = BUS_AW - 1,
  parameter logic [CODEC_AW-1:0] GPIO_ADDR = 7'h54
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 busWrite,
  input  logic [BUS_AW-1:1]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 frameStrobe,
  input  logic [DATA_W-1:0]    gpioSlotData,
  input  logic                 stsValid,
  input  logic [CODEC_AW-1:0]  stsAddr,
  input  logic [DATA_W-1:0]    stsData,
  output logic                 isGpioRead,
  output logic                 stsMatch,
  output logic                 capWrite,
  output logic [CODEC_AW-1:0]  capAddr,
  output logic [DATA_W-1:0]    capData,
  output logic [BUS_W-1:0]     rdata
);
  localparam int PAD_W = BUS_W - DATA_W;

  logic [CODEC_AW-1:0] codecAddr;
  logic [DATA_W-1:0]   shadowGpio;

  // byte offset / 2 -> codec register address
  assign codecAddr  = busAddr;
  assign isGpioRead = !busWrite && (codecAddr == GPIO_ADDR);
  assign stsMatch   = stsValid && (stsAddr == capAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWrite <= 1'b0;
      capAddr  <= '0;
      capData  <= '0;
    end else if (strobe.capture) begin
      capWrite <= busWrite;
      capAddr  <= codecAddr;
      capData  <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            shadowGpio <= '0;
    else if (frameStrobe) shadowGpio <= gpioSlotData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  rdata <= '0;
    else if (strobe.loadShadow) rdata <= {{PAD_W{1'b0}}, shadowGpio};
    else if (strobe.loadSts)    rdata <= {{PAD_W{1'b0}}, stsData};
    else if (strobe.capture)    rdata <= '0;
  end

endmodule

// File: rtl/codec_bridge_ctrl.sv
module codec_bridge_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int TO_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReq,
  input  logic            isGpioRead,
  input  logic            capWrite,
  input  logic            stsMatch,
  input  logic            cmdTaken,
  input  logic            frameStrobe,
  input  logic [TO_W-1:0] cfgTimeoutFrames,
  output dpStrobe_t       strobe,
  output logic            cmdValid,
  output logic            busDone,
  output logic            busTimeout
);
  localparam int CMP_W = TO_W + 1;

  bridgeState_t    state, stateNext;
  logic [TO_W-1:0] frameCnt;
  logic            tmoReg, tmoNext;
  logic [CMP_W-1:0] limit, reached;

  assign limit   = (cfgTimeoutFrames == '0) ? CMP_W'(1) : {1'b0, cfgTimeoutFrames};
  assign reached = {1'b0, frameCnt} + CMP_W'(1);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    tmoNext   = tmoReg;
    case (state)
      ST_IDLE: begin
        if (busReq) begin
          strobe.capture = 1'b1;
          tmoNext        = 1'b0;
          if (isGpioRead) begin
            strobe.loadShadow = 1'b1;
            stateNext         = ST_DONE;
          end else begin
            stateNext = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (cmdTaken) stateNext = capWrite ? ST_DONE : ST_WAIT;
      end
      ST_WAIT: begin
        if (stsMatch) begin
          strobe.loadSts = 1'b1;
          stateNext      = ST_DONE;
        end else if (frameStrobe && (reached >= limit)) begin
          tmoNext   = 1'b1;
          stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tmoReg <= 1'b0;
    end else begin
      state  <= stateNext;
      tmoReg <= tmoNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || state != ST_WAIT) frameCnt <= '0;
    else if (frameStrobe)          frameCnt <= frameCnt + 1'b1;
  end

  assign cmdValid   = (state == ST_ISSUE);
  assign busDone    = (state == ST_DONE);
  assign busTimeout = busDone && tmoReg;

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32,
  parameter int TO_W   = 4,
  parameter int CODEC_AW = BUS_AW - 1,
  parameter logic [CODEC_AW-1:0] GPIO_ADDR = 7'h54
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWrite,
  input  logic [BUS_AW-1:1]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic                busDone,
  output logic [BUS_W-1:0]    busRdata,
  output logic                busTimeout,
  output logic                cmdValid,
  output logic                cmdWrite,
  output logic [CODEC_AW-1:0] cmdAddr,
  output logic [DATA_W-1:0]   cmdData,
  input  logic                cmdTaken,
  input  logic                frameStrobe,
  input  logic [DATA_W-1:0]   gpioSlotData,
  input  logic                stsValid,
  input  logic [CODEC_AW-1:0] stsAddr,
  input  logic [DATA_W-1:0]   stsData,
  input  logic [TO_W-1:0]     cfgTimeoutFrames
);
  dpStrobe_t strobe;
  logic      isGpioRead, stsMatch, capWrite;

  codec_bridge_ctrl #(.TO_W(TO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .isGpioRead(isGpioRead),
    .capWrite(capWrite), .stsMatch(stsMatch), .cmdTaken(cmdTaken),
    .frameStrobe(frameStrobe), .cfgTimeoutFrames(cfgTimeoutFrames),
    .strobe(strobe), .cmdValid(cmdValid), .busDone(busDone), .busTimeout(busTimeout)
  );

  codec_bridge_dp #(
    .BUS_AW(BUS_AW), .DATA_W(DATA_W), .BUS_W(BUS_W),
    .CODEC_AW(CODEC_AW), .GPIO_ADDR(GPIO_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .frameStrobe(frameStrobe),
    .gpioSlotData(gpioSlotData), .stsValid(stsValid), .stsAddr(stsAddr),
    .stsData(stsData), .isGpioRead(isGpioRead), .stsMatch(stsMatch),
    .capWrite(capWrite), .capAddr(cmdAddr), .capData(cmdData), .rdata(busRdata)
  );

  assign cmdWrite = capWrite;

endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk #(
  parameter int CODEC_AW = 7,
  parameter int BUS_W    = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busDone,
  input logic                busTimeout,
  input logic [BUS_W-1:0]    busRdata,
  input logic                cmdValid,
  input logic                cmdTaken,
  input logic                cmdWrite,
  input logic [CODEC_AW-1:0] cmdAddr
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busDone |=> !busDone); // R10

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdTaken) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdWrite))); // R9

  AST_NO_CMD_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busDone |-> !cmdValid); // R9

  AST_TMO_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busTimeout |-> (busDone && busRdata == '0)); // R8

  AST_RDATA_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    busDone |-> (busRdata[BUS_W-1:16] == '0)); // R4

  AST_TAKEN_ENDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdTaken) |=> !cmdValid); // R9

endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(.CODEC_AW(CODEC_AW), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rstN(rstN), .busDone(busDone), .busTimeout(busTimeout),
  .busRdata(busRdata), .cmdValid(cmdValid), .cmdTaken(cmdTaken),
  .cmdWrite(cmdWrite), .cmdAddr(cmdAddr)
);

// File: tb/codec_reg_bridge_tb.sv
module codec_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0;
  logic [7:1]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busDone, busTimeout;
  logic [31:0] busRdata;
  logic        cmdValid, cmdWrite;
  logic [6:0]  cmdAddr;
  logic [15:0] cmdData;
  logic        cmdTaken = 1'b0, frameStrobe = 1'b0, stsValid = 1'b0;
  logic [15:0] gpioSlotData = '0, stsData = '0;
  logic [6:0]  stsAddr = '0;
  logic [3:0]  cfgTimeoutFrames = 4'd3;

  int checks = 0;
  int errors = 0;
  logic [15:0] expShadow = '0;

  always #2.5 clk = ~clk;

  codec_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busDone(busDone),
    .busRdata(busRdata), .busTimeout(busTimeout), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdTaken(cmdTaken), .frameStrobe(frameStrobe), .gpioSlotData(gpioSlotData),
    .stsValid(stsValid), .stsAddr(stsAddr), .stsData(stsData),
    .cfgTimeoutFrames(cfgTimeoutFrames)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] codecOf(input logic [7:0] off);
    return off[7:1];
  endfunction

  function automatic int effLimit(input logic [3:0] cfg);
    return (cfg == 0) ? 1 : int'(cfg);
  endfunction

  task automatic sendFrame(input logic [15:0] g);
    frameStrobe  = 1'b1;
    gpioSlotData = g;
    @(negedge clk);
    frameStrobe = 1'b0;
    expShadow   = g;
  endtask

  task automatic endTxn();
    busReq = 1'b0;
    @(negedge clk);
    check("R10 done single cycle", {31'b0, busDone}, 32'd0);
  endtask

  // respAt < 0: never answer; otherwise answer after respAt frames
  task automatic doTxn(input logic wr, input logic [7:0] off, input logic [15:0] wd,
                       input int respAt, input logic [15:0] rd, input logic badSts);
    logic [6:0] ca;
    ca = codecOf(off);
    busReq = 1'b1; busWrite = wr; busAddr = off[7:1]; busWdata = wd;
    @(negedge clk);
    if (!wr && ca == 7'h54) begin
      check("R6 gpio read no cmd", {31'b0, cmdValid}, 32'd0);
      check("R6 gpio read done", {31'b0, busDone}, 32'd1);
      check("R6 R7 gpio shadow data", busRdata, {16'h0, expShadow});
      endTxn();
      return;
    end
    check("R3 R4 cmd raised", {31'b0, cmdValid}, 32'd1);
    check("R2 codec address", {25'b0, cmdAddr}, {25'b0, ca});
    check("R3 R4 cmd direction", {31'b0, cmdWrite}, {31'b0, wr});
    if (wr) check("R3 cmd data", {16'b0, cmdData}, {16'b0, wd});
    @(negedge clk);
    check("R9 cmd held until taken", {31'b0, cmdValid}, 32'd1);
    cmdTaken = 1'b1;
    @(negedge clk);
    cmdTaken = 1'b0;
    if (wr) begin
      check("R3 write done after taken", {31'b0, busDone}, 32'd1);
      check("R3 write no timeout", {31'b0, busTimeout}, 32'd0);
      endTxn();
      return;
    end
    check("R9 no cmd while pending", {31'b0, cmdValid | busDone}, 32'd0);
    for (int f = 0; ; f++) begin
      if (respAt >= 0 && f == respAt) begin
        if (badSts) begin
          stsValid = 1'b1; stsAddr = ca ^ 7'h02; stsData = ~rd;
          @(negedge clk);
          stsValid = 1'b0;
          check("R5 mismatched status ignored", {31'b0, busDone}, 32'd0);
        end
        stsValid = 1'b1; stsAddr = ca; stsData = rd;
        @(negedge clk);
        stsValid = 1'b0;
        check("R4 read done on match", {31'b0, busDone}, 32'd1);
        check("R4 read data zero-extended", busRdata, {16'h0, rd});
        check("R4 no timeout", {31'b0, busTimeout}, 32'd0);
        break;
      end
      sendFrame(16'($urandom));
      if (f + 1 == effLimit(cfgTimeoutFrames)) begin
        check("R8 timeout done", {31'b0, busDone}, 32'd1);
        check("R8 timeout flag", {31'b0, busTimeout}, 32'd1);
        check("R8 timeout data zero", busRdata, 32'd0);
        break;
      end
      check("R8 R9 still pending", {31'b0, busDone | cmdValid}, 32'd0);
    end
    endTxn();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check("R1 reset done", {31'b0, busDone}, 32'd0);
    check("R1 reset cmd", {31'b0, cmdValid}, 32'd0);
    check("R1 reset timeout", {31'b0, busTimeout}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: shadow is zero before any frame
    doTxn(1'b0, 8'hA8, 16'h0, -1, 16'h0, 1'b0);
    // R7: shadow follows frames
    sendFrame(16'h5A3C);
    sendFrame(16'hC0DE);
    doTxn(1'b0, 8'hA8, 16'h0, -1, 16'h0, 1'b0);
    // R3: GPIO write goes over the link
    doTxn(1'b1, 8'hA8, 16'h1234, -1, 16'h0, 1'b0);
    // R4 R5: read answered after a stray status
    doTxn(1'b0, 8'h10, 16'h0, 1, 16'hBEEF, 1'b1);
    // R8: timeout at limit 3
    doTxn(1'b0, 8'h7C, 16'h0, -1, 16'h0, 1'b0);
    // R8: limit 0 acts as 1
    cfgTimeoutFrames = 4'd0;
    doTxn(1'b0, 8'h04, 16'h0, -1, 16'h0, 1'b0);
    // R10: request held through the done cycle is not re-taken
    busReq = 1'b1; busWrite = 1'b0; busAddr = 7'h54;
    @(negedge clk);
    check("R10 held request done", {31'b0, busDone}, 32'd1);
    @(negedge clk);
    check("R10 held request not repeated", {31'b0, busDone}, 32'd0);
    busReq = 1'b0;
    @(negedge clk);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] off;
      logic       wr;
      int         lim, resp;
      cfgTimeoutFrames = 4'($urandom_range(0, 5));
      lim = effLimit(cfgTimeoutFrames);
      off = ($urandom_range(0, 3) == 0) ? 8'hA8 : {6'($urandom), 2'b00};
      wr  = 1'($urandom);
      resp = ($urandom_range(0, 3) == 0) ? -1 : $urandom_range(0, lim - 1);
      if ($urandom_range(0, 1) == 1) sendFrame(16'($urandom));
      doTxn(wr, off, 16'($urandom), resp, 16'($urandom), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule